// File: doc/BRIEF.md
# Two-Way Copy-Back Cache Tag Controller

This block holds the tags and makes the control decisions for a two-way set-associative secondary cache that runs in copy-back mode. Two upper-level sources send requests to it independently. The instruction side only loads. The data side loads, stores, or hands down an evicted upper-level line. Each accepted request is looked up in the tag store in the cycle it is accepted. A hit is answered one cycle later.

A miss, or any request flagged as caching-inhibited, goes out to the bus interface as a single-cycle request pulse. When the request is allowed to allocate, a line is reserved in the set. If that line holds modified data, its address is pushed out on a castout port in the same cycle. When the bus signals completion, the new tag is written into the reserved way while the fill data passes upward. A line filled by a burst load is left unmodified. Only one miss is in flight at a time. Both request ports stall until that miss is finished.

Top module: `cache_l2_tagctl`

## Requirements
- R1: After reset every way of every set is invalid, both ready outputs are high and no response, bus request or castout is active; the first access to any address misses.
- R2: When both sides present a request in the same cycle, the data side is accepted and `i_ready` is low for as long as `d_valid` is high; the instruction request is taken in a later cycle.
- R3: A request that matches a valid way and is not caching-inhibited gives `resp_valid` with `resp_hit`=1 in the cycle after acceptance, `resp_src` 1 for the data side and 0 for the instruction side, and no bus request.
- R4: A miss, or any caching-inhibited request (even one whose tag matches), raises `bus_req_valid` for exactly one cycle, in the cycle after acceptance, with the request address on `bus_req_addr`. A caching-inhibited request never installs a line, so repeating it misses again.
- R5: A burst load that misses and is not caching-inhibited installs its tag when `bus_done` is seen. The line is marked valid and unmodified, so a later eviction of that line gives no castout.
- R6: Stores (`d_op`=1) and upper-level castouts (`d_op`=2) that miss also allocate, and they install the line as modified. A non-burst load miss (`d_op`=0, burst low) allocates nothing.
- R7: A store or castout that hits sets the modified bit of the line it hits. A load hit leaves that bit unchanged.
- R8: When an allocating miss picks a victim that is valid and modified, `co_valid` pulses in the same cycle as `bus_req_valid`. `co_addr` carries the victim's tag and set index, with zero offset bits.
- R9: The victim way is way 0 if it is invalid, otherwise way 1 if it is invalid, otherwise the least recently used way of the set. A hit or an install makes the other way of that set the least recently used.
- R10: From the cycle after a miss is accepted until the cycle after `bus_done` is sampled, both ready outputs are low. The answer to the miss is `resp_valid` with `resp_hit`=0 in the cycle after `bus_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_valid | input | 1 | Instruction-side request present |
| i_ready | output | 1 | Instruction-side request accepted this cycle |
| i_addr | input | ADDR_W | Instruction-side byte address |
| i_burst | input | 1 | Instruction-side request is a burst (line) read |
| i_cinh | input | 1 | Instruction-side page is caching-inhibited |
| d_valid | input | 1 | Data-side request present |
| d_ready | output | 1 | Data-side request accepted this cycle |
| d_addr | input | ADDR_W | Data-side byte address |
| d_op | input | 2 | Data-side kind: 0 load, 1 store, 2 upper-level castout |
| d_burst | input | 1 | Data-side load is a burst read |
| d_cinh | input | 1 | Data-side page is caching-inhibited |
| resp_valid | output | 1 | Answer for the last accepted request |
| resp_src | output | 1 | Requester of the answer: 1 data, 0 instruction |
| resp_hit | output | 1 | 1 hit, 0 served by the bus |
| bus_req_valid | output | 1 | One-cycle request to the bus interface |
| bus_req_addr | output | ADDR_W | Address sent to the bus interface |
| bus_done | input | 1 | Bus transfer for the outstanding miss complete |
| co_valid | output | 1 | Modified victim leaving the cache |
| co_addr | output | ADDR_W | Line address of the modified victim |

## Verification
Two pairs of events can fall in the same cycle. The first pair is requests from both sides. The bench provokes it by raising both valids together, both when the data request hits and when it misses with a slow bus. It then judges the result from the order of the two answers on `resp_src` and from `i_ready` in every cycle. The second pair is a castout and a bus request. The bench provokes it by filling a set with a modified line and then forcing that line out with a store, an upper-level castout or a burst load. It judges the result by comparing `co_valid`, `co_addr` and `bus_req_addr` in the shared cycle against a behavioural model, which is also compared on every clock throughout a long random run.

// File: rtl/cache_tag_pkg.sv
package cache_tag_pkg;
    localparam logic [1:0] OP_LOAD    = 2'd0;
    localparam logic [1:0] OP_STORE   = 2'd1;
    localparam logic [1:0] OP_CASTOUT = 2'd2;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_MISS = 1'b1
    } ctl_state_e;
endpackage

// File: rtl/cache_req_arb.sv
module cache_req_arb (
    input  logic clk,
    input  logic rst_n,
    input  logic idle,
    input  logic d_valid,
    input  logic i_valid,
    output logic d_ready,
    output logic i_ready,
    output logic take,
    output logic pick_d
);
    assign d_ready = idle;
    assign i_ready = idle && !d_valid;
    assign pick_d  = d_valid;
    assign take    = idle && (d_valid || i_valid);

    assert_data_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (d_valid && i_valid && take) |-> pick_d);
endmodule

// File: rtl/cache_way_pick.sv
module cache_way_pick #(
    parameter int TAG_W = 8
) (
    input  logic [1:0]            way_valid,
    input  logic [1:0][TAG_W-1:0] way_tag,
    input  logic                  lru_way,
    input  logic [TAG_W-1:0]      req_tag,
    output logic                  hit,
    output logic                  hit_way,
    output logic                  victim_way
);
    logic [1:0] match;

    for (genvar w = 0; w < 2; w++) begin : g_cmp
        assign match[w] = way_valid[w] && (way_tag[w] == req_tag);
    end

    assign hit     = |match;
    assign hit_way = match[1];

    always_comb begin
        if (!way_valid[0])      victim_way = 1'b0;
        else if (!way_valid[1]) victim_way = 1'b1;
        else                    victim_way = lru_way;
    end
endmodule

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
    parameter int SETS  = 8,
    parameter int TAG_W = 8,
    parameter int IDX_W = $clog2(SETS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [1:0]            rd_valid,
    output logic [1:0]            rd_dirty,
    output logic [1:0][TAG_W-1:0] rd_tag,
    output logic                  rd_lru,
    input  logic                  touch_en,
    input  logic [IDX_W-1:0]      touch_idx,
    input  logic                  touch_way,
    input  logic                  touch_dirty,
    input  logic                  fill_en,
    input  logic [IDX_W-1:0]      fill_idx,
    input  logic                  fill_way,
    input  logic [TAG_W-1:0]      fill_tag,
    input  logic                  fill_dirty
);
    logic [SETS-1:0] lru_d, lru_q;

    for (genvar w = 0; w < 2; w++) begin : g_way
        logic [SETS-1:0]  v_d, v_q, m_d, m_q;
        logic [TAG_W-1:0] t_d [SETS];
        logic [TAG_W-1:0] t_q [SETS];

        always_comb begin
            v_d = v_q;
            m_d = m_q;
            t_d = t_q;
            if (touch_en && touch_way == 1'(w))
                m_d[touch_idx] = m_q[touch_idx] | touch_dirty;
            if (fill_en && fill_way == 1'(w)) begin
                v_d[fill_idx] = 1'b1;
                m_d[fill_idx] = fill_dirty;
                t_d[fill_idx] = fill_tag;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q <= '0;
                m_q <= '0;
                t_q <= '{default: '0};
            end else begin
                v_q <= v_d;
                m_q <= m_d;
                t_q <= t_d;
            end
        end

        assign rd_valid[w] = v_q[rd_idx];
        assign rd_dirty[w] = m_q[rd_idx];
        assign rd_tag[w]   = t_q[rd_idx];

        assert_fill_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (fill_en && fill_way == 1'(w)) |=>
                (v_q[$past(fill_idx)] && (m_q[$past(fill_idx)] == $past(fill_dirty))));
    end

    always_comb begin
        lru_d = lru_q;
        if (touch_en) lru_d[touch_idx] = ~touch_way;
        if (fill_en)  lru_d[fill_idx]  = ~fill_way;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lru_q <= '0;
        else        lru_q <= lru_d;
    end

    assign rd_lru = lru_q[rd_idx];

    assert_single_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(touch_en && fill_en));

    assert_lru_moves_R9: assert property (@(posedge clk) disable iff (!rst_n)
        touch_en |=> (lru_q[$past(touch_idx)] != $past(touch_way)));
endmodule

// File: rtl/cache_l2_tagctl.sv
module cache_l2_tagctl
    import cache_tag_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int SETS       = 8,
    parameter int LINE_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              i_valid,
    output logic              i_ready,
    input  logic [ADDR_W-1:0] i_addr,
    input  logic              i_burst,
    input  logic              i_cinh,
    input  logic              d_valid,
    output logic              d_ready,
    input  logic [ADDR_W-1:0] d_addr,
    input  logic [1:0]        d_op,
    input  logic              d_burst,
    input  logic              d_cinh,
    output logic              resp_valid,
    output logic              resp_src,
    output logic              resp_hit,
    output logic              bus_req_valid,
    output logic [ADDR_W-1:0] bus_req_addr,
    input  logic              bus_done,
    output logic              co_valid,
    output logic [ADDR_W-1:0] co_addr
);
    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

    typedef struct packed {
        ctl_state_e        state;
        logic [ADDR_W-1:0] p_addr;
        logic              p_src;
        logic              p_alloc;
        logic              p_wr;
        logic              p_way;
        logic              rv;
        logic              rh;
        logic              rs;
        logic              bv;
        logic [ADDR_W-1:0] ba;
        logic              cv;
        logic [ADDR_W-1:0] ca;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                  take, pick_d;
    logic [ADDR_W-1:0]     req_addr;
    logic                  req_burst, req_cinh, req_wr, req_alloc;
    logic [IDX_W-1:0]      req_idx;
    logic [TAG_W-1:0]      req_tag;
    logic [1:0]            way_valid, way_dirty;
    logic [1:0][TAG_W-1:0] way_tag;
    logic                  lru_way, hit, hit_way, victim_way;
    logic                  touch_en, touch_way, touch_dirty;
    logic                  fill_en, fill_way, fill_dirty;
    logic [IDX_W-1:0]      fill_idx;
    logic [TAG_W-1:0]      fill_tag;

    cache_req_arb u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .idle    (ctl_q.state == ST_IDLE),
        .d_valid (d_valid),
        .i_valid (i_valid),
        .d_ready (d_ready),
        .i_ready (i_ready),
        .take    (take),
        .pick_d  (pick_d)
    );

    assign req_addr  = pick_d ? d_addr  : i_addr;
    assign req_burst = pick_d ? d_burst : i_burst;
    assign req_cinh  = pick_d ? d_cinh  : i_cinh;
    assign req_wr    = pick_d && (d_op == OP_STORE || d_op == OP_CASTOUT);
    assign req_alloc = !req_cinh && (req_wr || req_burst);
    assign req_idx   = req_addr[OFF_W +: IDX_W];
    assign req_tag   = req_addr[ADDR_W-1 -: TAG_W];

    cache_tag_store #(.SETS(SETS), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_idx      (req_idx),
        .rd_valid    (way_valid),
        .rd_dirty    (way_dirty),
        .rd_tag      (way_tag),
        .rd_lru      (lru_way),
        .touch_en    (touch_en),
        .touch_idx   (req_idx),
        .touch_way   (touch_way),
        .touch_dirty (touch_dirty),
        .fill_en     (fill_en),
        .fill_idx    (fill_idx),
        .fill_way    (fill_way),
        .fill_tag    (fill_tag),
        .fill_dirty  (fill_dirty)
    );

    cache_way_pick #(.TAG_W(TAG_W)) u_pick (
        .way_valid  (way_valid),
        .way_tag    (way_tag),
        .lru_way    (lru_way),
        .req_tag    (req_tag),
        .hit        (hit),
        .hit_way    (hit_way),
        .victim_way (victim_way)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.rv    = 1'b0;
        ctl_d.bv    = 1'b0;
        ctl_d.cv    = 1'b0;
        touch_en    = 1'b0;
        touch_way   = hit_way;
        touch_dirty = req_wr;
        fill_en     = 1'b0;
        fill_way    = ctl_q.p_way;
        fill_idx    = ctl_q.p_addr[OFF_W +: IDX_W];
        fill_tag    = ctl_q.p_addr[ADDR_W-1 -: TAG_W];
        fill_dirty  = ctl_q.p_wr;

        if (ctl_q.state == ST_MISS) begin
            if (bus_done) begin
                ctl_d.rv    = 1'b1;
                ctl_d.rh    = 1'b0;
                ctl_d.rs    = ctl_q.p_src;
                fill_en     = ctl_q.p_alloc;
                ctl_d.state = ST_IDLE;
            end
        end else if (take) begin
            if (hit && !req_cinh) begin
                ctl_d.rv = 1'b1;
                ctl_d.rh = 1'b1;
                ctl_d.rs = pick_d;
                touch_en = 1'b1;
            end else begin
                ctl_d.bv      = 1'b1;
                ctl_d.ba      = req_addr;
                ctl_d.state   = ST_MISS;
                ctl_d.p_addr  = req_addr;
                ctl_d.p_src   = pick_d;
                ctl_d.p_alloc = req_alloc;
                ctl_d.p_wr    = req_wr;
                ctl_d.p_way   = victim_way;
                if (req_alloc && way_valid[victim_way] && way_dirty[victim_way]) begin
                    ctl_d.cv = 1'b1;
                    ctl_d.ca = {way_tag[victim_way], req_idx, {OFF_W{1'b0}}};
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign resp_valid    = ctl_q.rv;
    assign resp_hit      = ctl_q.rh;
    assign resp_src      = ctl_q.rs;
    assign bus_req_valid = ctl_q.bv;
    assign bus_req_addr  = ctl_q.ba;
    assign co_valid      = ctl_q.cv;
    assign co_addr       = ctl_q.ca;

    assert_instr_blocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        d_valid |-> !i_ready);

    assert_hit_no_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_hit) |-> !bus_req_valid);

    assert_bus_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid |=> !bus_req_valid);

    assert_castout_paired_R8: assert property (@(posedge clk) disable iff (!rst_n)
        co_valid |-> bus_req_valid);

    assert_stall_on_miss_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid |-> (!d_ready && !i_ready));
endmodule

// File: tb/tb_cache_l2_tagctl.sv
module tb_cache_l2_tagctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        i_valid = 1'b0, i_burst = 1'b0, i_cinh = 1'b0;
    logic [15:0] i_addr = '0;
    logic        d_valid = 1'b0, d_burst = 1'b0, d_cinh = 1'b0;
    logic [15:0] d_addr = '0;
    logic [1:0]  d_op = 2'd0;
    logic        bus_done = 1'b0;
    logic        i_ready, d_ready, resp_valid, resp_src, resp_hit;
    logic        bus_req_valid, co_valid;
    logic [15:0] bus_req_addr, co_addr;

    always #10 clk = ~clk;

    cache_l2_tagctl dut (
        .clk(clk), .rst_n(rst_n),
        .i_valid(i_valid), .i_ready(i_ready), .i_addr(i_addr), .i_burst(i_burst), .i_cinh(i_cinh),
        .d_valid(d_valid), .d_ready(d_ready), .d_addr(d_addr), .d_op(d_op), .d_burst(d_burst),
        .d_cinh(d_cinh), .resp_valid(resp_valid), .resp_src(resp_src), .resp_hit(resp_hit),
        .bus_req_valid(bus_req_valid), .bus_req_addr(bus_req_addr), .bus_done(bus_done),
        .co_valid(co_valid), .co_addr(co_addr)
    );

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    // behavioural reference model
    bit mv [2][8];
    bit md [2][8];
    int mt [2][8];
    int ml [8];
    bit m_busy;
    int p_src, p_way, p_idx, p_tag;
    bit p_alloc, p_wr;
    bit e_rv, e_rh, e_rs, e_bv, e_cv;
    logic [15:0] e_ba, e_ca;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < 2; w++)
                for (int s = 0; s < 8; s++) begin mv[w][s] = 0; md[w][s] = 0; mt[w][s] = 0; end
            for (int s = 0; s < 8; s++) ml[s] = 0;
            m_busy = 0; e_rv = 0; e_rh = 0; e_rs = 0; e_bv = 0; e_cv = 0; e_ba = 0; e_ca = 0;
        end else begin
            e_rv = 0; e_bv = 0; e_cv = 0;
            if (m_busy) begin
                if (bus_done) begin
                    e_rv = 1; e_rh = 0; e_rs = p_src[0];
                    if (p_alloc) begin
                        mv[p_way][p_idx] = 1; md[p_way][p_idx] = p_wr;
                        mt[p_way][p_idx] = p_tag; ml[p_idx] = 1 - p_way;
                    end
                    m_busy = 0;
                end
            end else if (d_valid || i_valid) begin
                int src, idx, tg, h, vic;
                bit wr, ci, bu;
                logic [15:0] a;
                src = d_valid ? 1 : 0;
                a   = d_valid ? d_addr : i_addr;
                ci  = d_valid ? d_cinh : i_cinh;
                bu  = d_valid ? d_burst : i_burst;
                wr  = d_valid && (d_op == 2'd1 || d_op == 2'd2);
                idx = int'(a[7:5]);
                tg  = int'(a[15:8]);
                h = -1;
                for (int w = 0; w < 2; w++) if (mv[w][idx] && mt[w][idx] == tg) h = w;
                if (h >= 0 && !ci) begin
                    e_rv = 1; e_rh = 1; e_rs = src[0];
                    if (wr) md[h][idx] = 1;
                    ml[idx] = 1 - h;
                end else begin
                    e_bv = 1; e_ba = a;
                    vic = !mv[0][idx] ? 0 : (!mv[1][idx] ? 1 : ml[idx]);
                    p_alloc = !ci && (wr || bu);
                    if (p_alloc && mv[vic][idx] && md[vic][idx]) begin
                        e_cv = 1; e_ca = {mt[vic][idx][7:0], a[7:5], 5'd0};
                    end
                    p_src = src; p_way = vic; p_idx = idx; p_tag = tg; p_wr = wr;
                    m_busy = 1;
                end
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // next-cycle stimulus and bus responder
    bit nx_iv, nx_ib, nx_ic, nx_dv, nx_db, nx_dc;
    logic [15:0] nx_ia, nx_da;
    logic [1:0] nx_dop;
    bit b_pend; int b_wait, lat;
    int resp_cnt, first_src, last_hit, saw_co;
    logic [15:0] saw_co_addr;

    task automatic step();
        @(negedge clk);
        chk("R3 resp_valid", resp_valid, e_rv);
        if (e_rv) begin
            chk("R3 resp_hit", resp_hit, e_rh);
            chk("R3 resp_src", resp_src, e_rs);
        end
        chk("R4 bus_req_valid", bus_req_valid, e_bv);
        if (e_bv) chk("R4 bus_req_addr", bus_req_addr, e_ba);
        chk("R8 co_valid", co_valid, e_cv);
        if (e_cv) chk("R8 co_addr", co_addr, e_ca);
        if (resp_valid) begin
            if (resp_cnt == 0) first_src = resp_src;
            resp_cnt++; last_hit = resp_hit;
        end
        if (co_valid) begin saw_co = 1; saw_co_addr = co_addr; end
        if (bus_req_valid) begin b_pend = 1; b_wait = lat; end
        bus_done = b_pend && b_wait == 0;
        if (b_pend) begin
            if (b_wait == 0) b_pend = 0;
            else b_wait--;
        end
        i_valid = nx_iv; i_addr = nx_ia; i_burst = nx_ib; i_cinh = nx_ic;
        d_valid = nx_dv; d_addr = nx_da; d_op = nx_dop; d_burst = nx_db; d_cinh = nx_dc;
        #1;
        chk("R2 R10 d_ready", d_ready, (rst_n && m_busy) ? 0 : 1);
        chk("R2 R10 i_ready", i_ready, (rst_n && (m_busy || d_valid)) ? 0 : 1);
    endtask

    function automatic logic [15:0] mk(int t, int s);
        return {t[7:0], s[2:0], 5'd0};
    endfunction

    task automatic clear_marks();
        resp_cnt = 0; saw_co = 0; saw_co_addr = 0; first_src = -1; last_hit = -1;
    endtask

    task automatic issue(bit side_d, int op, bit bu, bit ci, logic [15:0] a);
        bit acc;
        clear_marks();
        if (side_d) begin
            nx_dv = 1; nx_da = a; nx_dop = op[1:0]; nx_db = bu; nx_dc = ci;
        end else begin
            nx_iv = 1; nx_ia = a; nx_ib = bu; nx_ic = ci;
        end
        acc = 0;
        while (!acc) begin
            step();
            if (side_d ? (d_valid && d_ready) : (i_valid && i_ready)) acc = 1;
        end
        nx_dv = 0; nx_iv = 0;
        while (resp_cnt == 0) step();
    endtask

    task automatic dual(logic [15:0] ia, bit ib, int dop, logic [15:0] da, bit db);
        bit acc_i, acc_d;
        clear_marks();
        nx_iv = 1; nx_ia = ia; nx_ib = ib; nx_ic = 0;
        nx_dv = 1; nx_da = da; nx_dop = dop[1:0]; nx_db = db; nx_dc = 0;
        acc_i = 0; acc_d = 0;
        while (!(acc_i && acc_d)) begin
            step();
            if (d_valid && d_ready) begin acc_d = 1; nx_dv = 0; end
            if (i_valid && i_ready) begin acc_i = 1; nx_iv = 0; end
        end
        while (resp_cnt < 2) step();
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog R10 actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        nx_iv = 0; nx_ia = 0; nx_ib = 0; nx_ic = 0;
        nx_dv = 0; nx_da = 0; nx_dop = 0; nx_db = 0; nx_dc = 0;
        b_pend = 0; b_wait = 0; lat = 1;
        clear_marks();
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R1 d_ready after reset", d_ready, 1);
        chk("R1 i_ready after reset", i_ready, 1);
        chk("R1 no response after reset", resp_valid, 0);
        chk("R1 no bus request after reset", bus_req_valid, 0);

        issue(1, 0, 1, 0, mk(1, 1));
        chk("R1 first access misses", last_hit, 0);
        issue(1, 0, 0, 0, mk(1, 1));
        chk("R5 burst fill installs line", last_hit, 1);
        lat = 2;
        issue(0, 0, 1, 0, mk(2, 1));
        chk("R1 instruction line misses", last_hit, 0);
        issue(0, 0, 0, 0, mk(2, 1));
        chk("R9 invalid way filled", last_hit, 1);
        issue(1, 0, 0, 0, mk(1, 1));
        chk("R9 other way kept", last_hit, 1);
        issue(1, 1, 0, 0, mk(1, 1));
        chk("R7 store hit", last_hit, 1);
        issue(1, 0, 1, 0, mk(3, 1));
        chk("R9 LRU clean victim no castout", saw_co, 0);
        lat = 0;
        issue(1, 0, 1, 0, mk(4, 1));
        chk("R7 store hit made line modified", saw_co, 1);
        chk("R8 castout address", saw_co_addr, mk(1, 1));
        issue(1, 0, 1, 0, mk(5, 1));
        chk("R5 burst filled line evicted clean", saw_co, 0);

        lat = 3;
        issue(1, 0, 1, 1, mk(6, 2));
        chk("R4 cinh goes to bus", last_hit, 0);
        issue(1, 0, 1, 1, mk(6, 2));
        chk("R4 cinh repeat still misses", last_hit, 0);
        issue(1, 0, 0, 0, mk(6, 2));
        chk("R4 cinh did not allocate", last_hit, 0);

        issue(1, 0, 0, 0, mk(7, 3));
        issue(1, 0, 0, 0, mk(7, 3));
        chk("R6 non-burst load no allocate", last_hit, 0);
        issue(1, 1, 0, 0, mk(7, 3));
        issue(1, 0, 0, 0, mk(7, 3));
        chk("R6 store miss allocates", last_hit, 1);
        issue(1, 0, 1, 0, mk(8, 3));
        issue(1, 0, 1, 0, mk(9, 3));
        chk("R6 store install modified", saw_co, 1);
        chk("R6 castout address", saw_co_addr, mk(7, 3));

        lat = 1;
        issue(1, 2, 0, 0, mk(10, 4));
        issue(0, 0, 1, 0, mk(11, 4));
        issue(1, 0, 1, 0, mk(12, 4));
        chk("R6 castout miss installs modified", saw_co, 1);
        chk("R6 castout victim address", saw_co_addr, mk(10, 4));

        issue(1, 0, 1, 0, mk(13, 5));
        issue(1, 2, 0, 0, mk(13, 5));
        chk("R7 castout hit", last_hit, 1);
        issue(0, 0, 1, 0, mk(14, 5));
        issue(1, 0, 1, 0, mk(15, 5));
        chk("R7 castout hit made line modified", saw_co, 1);
        chk("R7 castout hit victim address", saw_co_addr, mk(13, 5));

        issue(1, 0, 0, 0, mk(9, 3));
        chk("R3 hit after refill", last_hit, 1);
        dual(mk(9, 3), 0, 0, mk(8, 3), 0);
        chk("R2 data side answered first", first_src, 1);
        lat = 3;
        dual(mk(9, 3), 0, 0, mk(20, 6), 1);
        chk("R10 data miss answered before instruction", first_src, 1);
        chk("R3 instruction hit after miss", last_hit, 1);

        for (int k = 0; k < 600; k++) begin
            int sd, op, sel;
            logic [15:0] a;
            lat = $urandom_range(0, 3);
            a = mk($urandom_range(0, 3), $urandom_range(0, 1)) | 16'($urandom_range(0, 31));
            sel = $urandom_range(0, 9);
            op = $urandom_range(0, 2);
            if (sel == 0) begin
                dual(a, 1, op, mk($urandom_range(0, 3), $urandom_range(0, 1)), $urandom_range(0, 1));
            end else begin
                sd = (sel < 6) ? 1 : 0;
                issue(sd[0], sd ? op : 0, $urandom_range(0, 1), ($urandom_range(0, 7) == 0), a);
            end
        end
        repeat (4) step();
        finished = 1;
        summary();
        $finish;
    end
endmodule